// File: doc/BRIEF.md
# Serial Ninth-Bit Holder and Service Request Router

This block sits beside the data register of an asynchronous serial transceiver. It keeps the ninth data bit of the last received character and the ninth data bit of the next character to send. It also decides where each service event goes. A receiver-full event and a transmitter-empty event each reach exactly one consumer: either a CPU interrupt line or a DMA request line, chosen by an enable bit.

Software reaches the block through a single 8-bit control register, with a write strobe and a combinational read. The receiver core reports each finished character with a one-cycle pulse that carries the 9-bit character and the current character length. A second pulse tells the block that the data register has been read. The transmitter core gives a one-cycle pulse when its shift register loads, and a level that is high while the data register is empty.

The handshakes are plain strobes and levels. The block applies no back-pressure: a new character always overwrites the held ninth bit and sets the full flag again.

Top module: `sci9_steer`

## Requirements
- R1: When `rx_done` is high and `rx_nine_mode` is 1, the received ninth bit (control bit 1) takes `rx_data[8]`. The new value is visible after that clock edge.
- R2: When `rx_done` is high and `rx_nine_mode` is 0, control bit 1 takes a copy of `rx_data[7]`.
- R3: Control bit 1 is read-only. A bus write leaves it unchanged.
- R4: Control bit 0 (transmit ninth bit) is read/write. On a clock edge where `tx_load` is high, `tx_bit8` takes the value bit 0 held before that edge, and keeps it until the next load.
- R5: Reset changes neither control bit 0, control bit 1, nor `tx_bit8`.
- R6: Reset clears the four enable bits and the receiver-full flag. The enables are bit 2 (receive DMA), bit 3 (transmit DMA), bit 4 (receive interrupt enable) and bit 5 (transmit interrupt enable). The receiver-full flag reads on bit 6, and bit 7 reads `tx_empty`.
- R7: When the receiver-full flag is set and bit 4 is set: `rx_dma_req` is high if bit 2 is 1, and `rx_irq` is high if bit 2 is 0.
- R8: With bit 4 clear, neither `rx_irq` nor `rx_dma_req` is asserted, whatever the value of bit 2.
- R9: When `tx_empty` is high and bit 5 is set: `tx_dma_req` is high if bit 3 is 1, and `tx_irq` is high if bit 3 is 0. With bit 5 clear, both are low.
- R10: `rx_done` sets the receiver-full flag. `rx_taken` clears it, and `rx_done` wins when both are high in the same cycle. The receive requests are levels that follow the flag, and the transmit requests follow `tx_empty`.
- R11: The interrupt and the DMA request of the same event are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Control register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Control register read value |
| rx_done | input | 1 | Character-complete pulse from the receiver core |
| rx_data | input | 9 | Received character |
| rx_nine_mode | input | 1 | 1 = 9-bit characters, 0 = 8-bit characters |
| rx_taken | input | 1 | Data register was read; clears the full flag |
| tx_load | input | 1 | Transmit shift register load pulse |
| tx_empty | input | 1 | Transmit data register empty level |
| tx_bit8 | output | 1 | Ninth bit loaded into the shift register |
| rx_irq | output | 1 | Receiver CPU interrupt |
| rx_dma_req | output | 1 | Receiver DMA request |
| tx_irq | output | 1 | Transmitter CPU interrupt |
| tx_dma_req | output | 1 | Transmitter DMA request |

## Verification
Characters are received in both length modes, with bits 7 and 8 differing. This separates a correct capture from one that uses the wrong bit index or ignores the mode. Random combinations of the four enables, with the full flag and the empty level both up and down, check the routing: a swapped route, a missing interrupt-enable gate, or a request that outlives its flag each give a visible difference. Directed cases cover a write that tries to change the read-only bit, a bus write and a shift-register load in the same cycle, and a reset with both ninth bits set to known values.

// File: rtl/sci9_pkg.sv
package sci9_pkg;
  localparam int BUS_W  = 8;
  localparam int CHAR_W = 9;

  // Control register bit positions
  localparam int B_TX9  = 0;
  localparam int B_RX9  = 1;
  localparam int B_RDMA = 2;
  localparam int B_TDMA = 3;
  localparam int B_RIE  = 4;
  localparam int B_TIE  = 5;
  localparam int B_RXF  = 6;
  localparam int B_TXE  = 7;

  localparam int NCH = 2;  // event channels: 0 = receive, 1 = transmit

  typedef struct packed {
    logic tie;
    logic rie;
    logic tdma;
    logic rdma;
  } sci9_en_t;
endpackage

// File: rtl/sci9_enables.sv
module sci9_enables
  import sci9_pkg::*;
#(
  parameter int W = BUS_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [W-1:0]   wdata,
  output sci9_en_t       en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0;
    end else if (wr) begin
      en.rdma <= wdata[B_RDMA];
      en.tdma <= wdata[B_TDMA];
      en.rie  <= wdata[B_RIE];
      en.tie  <= wdata[B_TIE];
    end
  end
endmodule

// File: rtl/sci9_rx_hold.sv
module sci9_rx_hold #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [CW-1:0] data,
  input  logic          nine_mode,
  input  logic          taken,
  output logic          ninth,
  output logic          full
);
  localparam int TOP  = CW - 1;
  localparam int NEXT = CW - 2;

  // Ninth bit has no reset: it keeps its value through reset.
  always_ff @(posedge clk) begin
    if (done) ninth <= nine_mode ? data[TOP] : data[NEXT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     full <= 1'b0;
    else if (done)  full <= 1'b1;
    else if (taken) full <= 1'b0;
  end
endmodule

// File: rtl/sci9_tx_hold.sv
module sci9_tx_hold
  import sci9_pkg::*;
#(
  parameter int W = BUS_W
) (
  input  logic         clk,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic         ninth,
  output logic         shift_bit8
);
  // Neither register is reset.
  always_ff @(posedge clk) begin
    if (wr)   ninth      <= wdata[B_TX9];
    if (load) shift_bit8 <= ninth;
  end
endmodule

// File: rtl/sci9_route.sv
module sci9_route (
  input  logic flag,
  input  logic ie,
  input  logic dma_sel,
  output logic irq,
  output logic dreq
);
  logic live;
  assign live = flag & ie;
  assign irq  = live & ~dma_sel;
  assign dreq = live &  dma_sel;
endmodule

// File: rtl/sci9_steer.sv
module sci9_steer
  import sci9_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rx_done,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_nine_mode,
  input  logic              rx_taken,
  input  logic              tx_load,
  input  logic              tx_empty,
  output logic              tx_bit8,
  output logic              rx_irq,
  output logic              rx_dma_req,
  output logic              tx_irq,
  output logic              tx_dma_req
);
  sci9_en_t en;
  logic rx9, rxf, tx9;
  logic [NCH-1:0] ev_flag, ev_ie, ev_sel, ev_irq, ev_dreq;

  sci9_enables #(.W(BUS_W)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata), .en(en)
  );

  sci9_rx_hold #(.CW(CHAR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .done(rx_done), .data(rx_data),
    .nine_mode(rx_nine_mode), .taken(rx_taken), .ninth(rx9), .full(rxf)
  );

  sci9_tx_hold #(.W(BUS_W)) u_tx (
    .clk(clk), .wr(bus_wr), .wdata(bus_wdata), .load(tx_load),
    .ninth(tx9), .shift_bit8(tx_bit8)
  );

  assign ev_flag = {tx_empty, rxf};
  assign ev_ie   = {en.tie,   en.rie};
  assign ev_sel  = {en.tdma,  en.rdma};

  for (genvar g = 0; g < NCH; g++) begin : g_route
    sci9_route u_rt (
      .flag(ev_flag[g]), .ie(ev_ie[g]), .dma_sel(ev_sel[g]),
      .irq(ev_irq[g]), .dreq(ev_dreq[g])
    );
  end

  assign rx_irq     = ev_irq[0];
  assign rx_dma_req = ev_dreq[0];
  assign tx_irq     = ev_irq[1];
  assign tx_dma_req = ev_dreq[1];

  always_comb begin
    bus_rdata         = '0;
    bus_rdata[B_TX9]  = tx9;
    bus_rdata[B_RX9]  = rx9;
    bus_rdata[B_RDMA] = en.rdma;
    bus_rdata[B_TDMA] = en.tdma;
    bus_rdata[B_RIE]  = en.rie;
    bus_rdata[B_TIE]  = en.tie;
    bus_rdata[B_RXF]  = rxf;
    bus_rdata[B_TXE]  = tx_empty;
  end
endmodule

// File: rtl/sci9_steer_chk.sv
module sci9_steer_chk
  import sci9_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              rx_done,
  input logic [CHAR_W-1:0] rx_data,
  input logic              rx_nine_mode,
  input logic              tx_load,
  input logic              tx_bit8,
  input logic              rx_irq,
  input logic              rx_dma_req,
  input logic              tx_irq,
  input logic              tx_dma_req
);
  assert_rx_nine_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_nine_mode |=> bus_rdata[B_RX9] == $past(rx_data[CHAR_W-1]));

  assert_rx_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_nine_mode |=> bus_rdata[B_RX9] == $past(rx_data[CHAR_W-2]));

  assert_tx_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_bit8 == $past(bus_rdata[B_TX9]));

  assert_rx_dma_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> bus_rdata[B_RDMA] && bus_rdata[B_RXF]);

  assert_rx_needs_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq || rx_dma_req) |-> bus_rdata[B_RIE]);

  assert_tx_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq || tx_dma_req) |-> bus_rdata[B_TIE] && bus_rdata[B_TXE]);

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> bus_rdata[B_RXF]);

  assert_rx_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_irq, rx_dma_req}));

  assert_tx_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_irq, tx_dma_req}));
endmodule

bind sci9_steer sci9_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rdata(bus_rdata), .rx_done(rx_done),
  .rx_data(rx_data), .rx_nine_mode(rx_nine_mode), .tx_load(tx_load),
  .tx_bit8(tx_bit8), .rx_irq(rx_irq), .rx_dma_req(rx_dma_req),
  .tx_irq(tx_irq), .tx_dma_req(tx_dma_req)
);

// File: tb/tb_sci9_steer.sv
`timescale 1ns/1ps
module tb_sci9_steer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0; logic [7:0] bus_wdata = 0; logic [7:0] bus_rdata;
  logic rx_done = 0; logic [8:0] rx_data = 0; logic rx_nine_mode = 0;
  logic rx_taken = 0, tx_load = 0, tx_empty = 0;
  logic tx_bit8, rx_irq, rx_dma_req, tx_irq, tx_dma_req;

  int checks = 0, errors = 0;
  bit m_tx9, m_rx9, m_rdma, m_tdma, m_rie, m_tie, m_rxf, m_b8;

  always #10 clk = ~clk;  // 50 MHz

  sci9_steer dut (.*);

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic bit f_rx_ninth(bit [8:0] d, bit nine);
    return nine ? d[8] : d[7];
  endfunction

  // The model advances by one clock edge using the inputs as currently driven.
  task automatic model_step(bit rst);
    if (rx_done) m_rx9 = f_rx_ninth(rx_data, rx_nine_mode);
    if (tx_load) m_b8 = m_tx9;
    if (bus_wr) m_tx9 = bus_wdata[0];
    if (rst) begin
      {m_rdma, m_tdma, m_rie, m_tie, m_rxf} = '0;
    end else begin
      if (bus_wr) {m_tie, m_rie, m_tdma, m_rdma} = bus_wdata[5:2];
      if (rx_done) m_rxf = 1; else if (rx_taken) m_rxf = 0;
    end
  endtask

  task automatic cycle(bit rst = 0);
    model_step(rst);
    @(negedge clk);
    bus_wr = 0; rx_done = 0; rx_taken = 0; tx_load = 0;
  endtask

  task automatic check_all();
    chk("R4 tx ninth readback", bus_rdata[0], m_tx9);
    chk("R1/R2 rx ninth", bus_rdata[1], m_rx9);
    chk("R6 enables", bus_rdata[5:2] == {m_tie, m_rie, m_tdma, m_rdma}, 1'b1);
    chk("R10 rx full flag", bus_rdata[6], m_rxf);
    chk("R4 tx_bit8", tx_bit8, m_b8);
    chk("R7/R8 rx_irq", rx_irq, m_rxf & m_rie & ~m_rdma);
    chk("R7/R8 rx_dma_req", rx_dma_req, m_rxf & m_rie & m_rdma);
    chk("R9 tx_irq", tx_irq, tx_empty & m_tie & ~m_tdma);
    chk("R9 tx_dma_req", tx_dma_req, tx_empty & m_tie & m_tdma);
    chk("R11 exclusive", (rx_irq & rx_dma_req) | (tx_irq & tx_dma_req), 1'b0);
  endtask

  initial begin
    void'($urandom(1234));
    @(negedge clk);
    cycle(1); cycle(1);
    // R6: reset state of the enables and the flag
    chk("R6 enables zero", bus_rdata[5:2] == 4'b0, 1'b1);
    chk("R6 flag zero", bus_rdata[6], 1'b0);
    rst_n = 1;
    // Give the ninth bits known values before comparing them.
    bus_wr = 1; bus_wdata = 8'h01; cycle();
    tx_load = 1; cycle();
    rx_done = 1; rx_data = 9'h100; rx_nine_mode = 1; cycle();
    check_all();
    // R1: bit 8 differs from bit 7
    rx_done = 1; rx_data = 9'h080; rx_nine_mode = 1; cycle();
    chk("R1 nine-bit capture", bus_rdata[1], 1'b0);
    // R2: 8-bit mode copies bit 7
    rx_done = 1; rx_data = 9'h080; rx_nine_mode = 0; cycle();
    chk("R2 eight-bit copy", bus_rdata[1], 1'b1);
    // R3: a write cannot clear the read-only bit
    bus_wr = 1; bus_wdata = 8'h00; cycle();
    chk("R3 read-only rx ninth", bus_rdata[1], 1'b1);
    // R4: a write and a load in the same cycle: the load takes the old value
    bus_wr = 1; bus_wdata = 8'h01; cycle();
    bus_wr = 1; bus_wdata = 8'h00; tx_load = 1; cycle();
    chk("R4 load takes old ninth", tx_bit8, 1'b1);
    chk("R4 write lands", bus_rdata[0], 1'b0);
    // R10: done wins over taken
    rx_done = 1; rx_taken = 1; rx_data = 9'h0; cycle();
    chk("R10 done wins", bus_rdata[6], 1'b1);
    rx_taken = 1; cycle();
    chk("R10 taken clears", bus_rdata[6], 1'b0);
    check_all();
    // Random phase
    for (int i = 0; i < 400; i++) begin
      rx_done      = ($urandom % 4) == 0;
      rx_data      = 9'($urandom);
      rx_nine_mode = 1'($urandom);
      rx_taken     = ($urandom % 3) == 0;
      tx_load      = ($urandom % 4) == 0;
      tx_empty     = 1'($urandom);
      bus_wr       = ($urandom % 5) == 0;
      bus_wdata    = 8'($urandom);
      cycle();
      check_all();
    end
    // R5: reset keeps both ninth bits and tx_bit8
    bus_wr = 1; bus_wdata = 8'h3D; rx_done = 1; rx_data = 9'h100;
    rx_nine_mode = 1; tx_load = 1; cycle();
    bus_wr = 1; bus_wdata = 8'h3D; cycle();
    check_all();
    rst_n = 0; cycle(1); cycle(1);
    rst_n = 1;
    chk("R5 tx ninth kept", bus_rdata[0], 1'b1);
    chk("R5 rx ninth kept", bus_rdata[1], 1'b1);
    chk("R5 tx_bit8 kept", tx_bit8, m_b8);
    chk("R6 enables cleared", bus_rdata[5:2] == 4'b0, 1'b1);
    tx_empty = 1;
    #1;
    chk("R6 no tx request after reset", tx_irq | tx_dma_req, 1'b0);
    check_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule